// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits in a receive path and decides whether an incoming frame should be kept, based on its 48-bit destination address. Addresses whose group bit is set are hashed into a 512-entry table of single-bit flags: the frame is accepted when the flag selected by the hash is set. Individual (non-group) addresses never reach the table. For them the block passes on the verdict of an external exact-match comparator. A promiscuous input overrides both paths and accepts everything.

The hash is a reflected CRC-32 seeded with all ones. It runs over the six address bytes one byte per clock, with the byte that goes out first on the wire handled first. The 32-bit result is bit-reversed, and its top nine bits select the table entry. Software programs the table one entry at a time through a 32-bit control word that carries an entry index and the value to store.

A controller with three states runs each lookup:
- `ST_IDLE` waits for an address strobe. On a strobe it captures the address and folds in the first byte, then takes the transition IDLE→HASH.
- `ST_HASH` folds in bytes two to six. After the last byte it takes HASH→LOOKUP.
- `ST_LOOKUP` reads the table, registers the verdict and the done pulse, then takes LOOKUP→IDLE.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `filt_done` and `filt_accept` are 0 and every table entry is 0, so a group address is rejected until an entry is programmed.
- R2: A strobe that the block takes at clock edge k gives `filt_done` high for exactly one cycle after edge k+6. `filt_accept` is 0 whenever `filt_done` is 0.
- R3: A strobe raised while a lookup is in progress (edges k+1 to k+6) is ignored: it produces no done pulse. A strobe held high continuously starts a new lookup every seven cycles.
- R4: A write with `tbl_wr` high stores bit 9 of `tbl_wdata` into the entry indexed by bits 8..0 and leaves all other entries unchanged. Bits 31..10 have no effect. The new value applies to lookups in later cycles.
- R5: The index is computed as follows. Start a reflected CRC-32 (polynomial 0xEDB88320, seed 0xFFFFFFFF, no final inversion). Feed it the bytes `rx_dst_addr[47:40]` first through `rx_dst_addr[7:0]` last, each byte least significant bit first. Then index bit (8-j) equals CRC bit j, for j = 0..8. This is bits 31..23 of the bit-reversed CRC.
- R6: An address is a group address when `rx_dst_addr[40]` (the least significant bit of the first byte) is 1. For a group address, `rx_exact_hit` has no effect.
- R7: With promiscuous mode off, a group address is accepted exactly when its table entry is 1 at the lookup edge.
- R8: With promiscuous mode off, an individual address is accepted exactly when `rx_exact_hit` was 1 at the strobe, whatever the table holds.
- R9: When `promisc_en` is 1 at the strobe, the frame is accepted whatever the table and `rx_exact_hit` hold.
- R10: Once all 512 entries are set, every group address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_addr_valid | input | 1 | Strobe marking a destination address to classify |
| rx_dst_addr | input | 48 | Destination address; bits 47:40 are the first byte on the wire |
| rx_exact_hit | input | 1 | Result of the external exact-match compare for individual addresses |
| promisc_en | input | 1 | Accept every frame |
| tbl_wr | input | 1 | Table write strobe |
| tbl_wdata | input | 32 | Control word: index in bits 8..0, value in bit 9 |
| filt_done | output | 1 | One-cycle pulse marking a valid verdict |
| filt_accept | output | 1 | Verdict, qualified by `filt_done` |

## Verification
The bench builds the block with its default parameters: six address bytes, a nine-bit index and 32-bit table words. This makes the full 512-entry table reachable with one write per entry, so the fill-everything case is exercised, and it checks real group addresses against their CRC-derived indices. The seven-cycle lookup period is short enough that a continuously held strobe shows both accepted and ignored strobes within about thirty cycles. A behavioural model predicts done and verdict every clock. This covers table writes that land close to the lookup edge and random group addresses in a partly filled table.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int          CRC_W          = 32;
    localparam int          BYTE_W         = 8;
    localparam logic [31:0] CRC_POLY_REFL  = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED       = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HASH   = 2'd1,
        ST_LOOKUP = 2'd2
    } mhf_state_e;

endpackage

// File: rtl/mhf_crc_step.sv
// One byte of a reflected CRC, unrolled bit by bit (LSB first).
module mhf_crc_step #(
    parameter int                       CRC_W  = mhf_pkg::CRC_W,
    parameter int                       BYTE_W = mhf_pkg::BYTE_W,
    parameter logic [CRC_W-1:0]         POLY   = mhf_pkg::CRC_POLY_REFL
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [BYTE_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    logic [CRC_W-1:0] stage [BYTE_W+1];

    assign stage[0] = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, data_in};

    for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
        assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY)
                                        : (stage[g] >> 1);
    end

    assign crc_out = stage[BYTE_W];

endmodule

// File: rtl/mhf_bitrev_index.sv
// Index taken from the top bits of the bit-reversed CRC:
// index bit (IDX_W-1-j) = crc bit j.
module mhf_bitrev_index #(
    parameter int CRC_W = mhf_pkg::CRC_W,
    parameter int IDX_W = 9
) (
    input  logic [CRC_W-1:0] crc_in,
    output logic [IDX_W-1:0] idx_out
);

    for (genvar j = 0; j < IDX_W; j++) begin : g_rev
        assign idx_out[IDX_W-1-j] = crc_in[j];
    end

    logic unused_crc_hi;
    assign unused_crc_hi = ^crc_in[CRC_W-1:IDX_W];

endmodule

// File: rtl/mhf_hash_table.sv
// Single-bit flag table kept in word-sized registers, one entry written per cycle.
module mhf_hash_table #(
    parameter int IDX_W  = 9,
    parameter int WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int BIT_W   = $clog2(WORD_W);
    localparam int WORDS   = ENTRIES / WORD_W;
    localparam int WSEL_W  = IDX_W - BIT_W;

    logic [ENTRIES-1:0] flat;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              hit_w;

        assign hit_w = wr_en && (wr_idx[IDX_W-1:BIT_W] == WSEL_W'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (hit_w) begin
                word_q[wr_idx[BIT_W-1:0]] <= wr_val;
            end
        end

        assign flat[w*WORD_W +: WORD_W] = word_q;
    end

    assign rd_bit = flat[rd_idx];

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 9,
    parameter int CFG_W      = 32,
    parameter int WORD_W     = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rx_addr_valid,
    input  logic [ADDR_BYTES*8-1:0] rx_dst_addr,
    input  logic                    rx_exact_hit,
    input  logic                    promisc_en,
    input  logic                    tbl_wr,
    input  logic [CFG_W-1:0]        tbl_wdata,
    output logic                    filt_done,
    output logic                    filt_accept
);

    localparam int              ADDR_W    = ADDR_BYTES * BYTE_W;
    localparam int              CNT_W     = $clog2(ADDR_BYTES + 1);
    localparam int              VAL_BIT   = IDX_W;
    localparam int              GRP_BIT   = ADDR_W - BYTE_W;
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(ADDR_BYTES - 1);

    mhf_state_e        state_q, state_d;
    logic              busy;
    logic              take_strobe;

    logic [ADDR_W-1:0] addr_sh_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_seed;
    logic [CRC_W-1:0]  crc_next;
    logic [BYTE_W-1:0] byte_in;
    logic [CNT_W-1:0]  cnt_q;
    logic              grp_q, prom_q, hit_q;

    logic [IDX_W-1:0]  lookup_idx;
    logic              tbl_bit;
    logic              verdict;
    logic              done_q, accept_q;

    assign busy        = (state_q != ST_IDLE);
    assign take_strobe = (state_q == ST_IDLE) && rx_addr_valid;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rx_addr_valid)      state_d = ST_HASH;
            ST_HASH:   if (cnt_q == LAST_BYTE) state_d = ST_LOOKUP;
            ST_LOOKUP:                         state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // ---------------- CRC datapath ----------------
    assign crc_seed = (state_q == ST_IDLE) ? CRC_SEED : crc_q;
    assign byte_in  = (state_q == ST_IDLE) ? rx_dst_addr[ADDR_W-1 -: BYTE_W]
                                           : addr_sh_q[ADDR_W-1 -: BYTE_W];

    mhf_crc_step #(
        .CRC_W  (CRC_W),
        .BYTE_W (BYTE_W),
        .POLY   (CRC_POLY_REFL)
    ) u_crc (
        .crc_in  (crc_seed),
        .data_in (byte_in),
        .crc_out (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_sh_q <= '0;
            crc_q     <= '0;
            cnt_q     <= '0;
            grp_q     <= 1'b0;
            prom_q    <= 1'b0;
            hit_q     <= 1'b0;
        end else if (take_strobe) begin
            crc_q     <= crc_next;
            addr_sh_q <= rx_dst_addr << BYTE_W;
            cnt_q     <= CNT_W'(1);
            grp_q     <= rx_dst_addr[GRP_BIT];
            prom_q    <= promisc_en;
            hit_q     <= rx_exact_hit;
        end else if (state_q == ST_HASH) begin
            crc_q     <= crc_next;
            addr_sh_q <= addr_sh_q << BYTE_W;
            cnt_q     <= cnt_q + CNT_W'(1);
        end
    end

    mhf_bitrev_index #(
        .CRC_W (CRC_W),
        .IDX_W (IDX_W)
    ) u_idx (
        .crc_in  (crc_q),
        .idx_out (lookup_idx)
    );

    // ---------------- flag table ----------------
    mhf_hash_table #(
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (tbl_wr),
        .wr_idx (tbl_wdata[IDX_W-1:0]),
        .wr_val (tbl_wdata[VAL_BIT]),
        .rd_idx (lookup_idx),
        .rd_bit (tbl_bit)
    );

    logic unused_cfg_hi;
    assign unused_cfg_hi = ^tbl_wdata[CFG_W-1:VAL_BIT+1];

    assign verdict = prom_q | (grp_q ? tbl_bit : hit_q);

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            done_q   <= (state_q == ST_LOOKUP);
            accept_q <= (state_q == ST_LOOKUP) && verdict;
        end
    end

    assign filt_done   = done_q;
    assign filt_accept = accept_q;

endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
    parameter int LAT = 6
) (
    input logic clk,
    input logic rst,
    input logic rx_addr_valid,
    input logic rx_grp,
    input logic rx_exact_hit,
    input logic promisc_en,
    input logic busy,
    input logic filt_done,
    input logic filt_accept
);

    localparam int CW = $clog2(LAT + 2) + 1;
    localparam logic [CW-1:0] DUE = CW'(LAT + 1);

    logic [CW-1:0] age_q;
    logic          prom_c, grp_c, hit_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q  <= '0;
            prom_c <= 1'b0;
            grp_c  <= 1'b0;
            hit_c  <= 1'b0;
        end else if (rx_addr_valid && !busy) begin
            age_q  <= CW'(1);
            prom_c <= promisc_en;
            grp_c  <= rx_grp;
            hit_c  <= rx_exact_hit;
        end else if (age_q == DUE) begin
            age_q  <= '0;
        end else if (age_q != '0) begin
            age_q  <= age_q + CW'(1);
        end
    end

    assert_done_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (age_q == DUE) |-> filt_done);

    assert_no_extra_done_R3: assert property (@(posedge clk) disable iff (rst)
        filt_done |-> (age_q == DUE));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        filt_done |=> !filt_done);

    assert_accept_qualified_R2: assert property (@(posedge clk) disable iff (rst)
        !filt_done |-> !filt_accept);

    assert_promisc_accept_R9: assert property (@(posedge clk) disable iff (rst)
        (filt_done && prom_c) |-> filt_accept);

    assert_unicast_exact_R8: assert property (@(posedge clk) disable iff (rst)
        (filt_done && !prom_c && !grp_c) |-> (filt_accept == hit_c));

endmodule

bind mcast_hash_filter mhf_checker #(
    .LAT (ADDR_BYTES)
) u_mhf_checker (
    .clk           (clk),
    .rst           (rst),
    .rx_addr_valid (rx_addr_valid),
    .rx_grp        (rx_dst_addr[GRP_BIT]),
    .rx_exact_hit  (rx_exact_hit),
    .promisc_en    (promisc_en),
    .busy          (busy),
    .filt_done     (filt_done),
    .filt_accept   (filt_accept)
);

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;

    localparam int NB   = 6;
    localparam int IW   = 9;
    localparam int NENT = 1 << IW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_addr_valid = 1'b0;
    logic [47:0] rx_dst_addr = '0;
    logic        rx_exact_hit = 1'b0;
    logic        promisc_en = 1'b0;
    logic        tbl_wr = 1'b0;
    logic [31:0] tbl_wdata = '0;
    logic        filt_done, filt_accept;

    always #2.5 clk = ~clk;

    mcast_hash_filter u_mcast_hash_filter (
        .clk           (clk),
        .rst           (rst),
        .rx_addr_valid (rx_addr_valid),
        .rx_dst_addr   (rx_dst_addr),
        .rx_exact_hit  (rx_exact_hit),
        .promisc_en    (promisc_en),
        .tbl_wr        (tbl_wr),
        .tbl_wdata     (tbl_wdata),
        .filt_done     (filt_done),
        .filt_accept   (filt_accept)
    );

    int    n_checks = 0;
    int    n_err    = 0;
    string cur_req  = "R1";

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (%s): actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // R5: index from the reflected CRC-32 over the six bytes
    function automatic logic [IW-1:0] hash_idx(input logic [47:0] a);
        logic [31:0]   crc = 32'hFFFFFFFF;
        logic [IW-1:0] idx;
        for (int i = 0; i < NB; i++) begin
            crc = crc ^ {24'd0, a[47-8*i -: 8]};
            for (int b = 0; b < 8; b++)
                crc = crc[0] ? ((crc >> 1) ^ 32'hEDB88320) : (crc >> 1);
        end
        for (int j = 0; j < IW; j++) idx[IW-1-j] = crc[j];
        return idx;
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [NENT-1:0] tbl_m;
    bit          m_busy, m_done, m_acc, m_grp, m_prom, m_hit;
    int          m_cnt;
    logic [47:0] m_addr;

    always @(posedge clk) begin
        if (rst) begin
            tbl_m  = '0;
            m_busy = 0; m_done = 0; m_acc = 0; m_cnt = 0;
        end else begin
            m_done = 0;
            m_acc  = 0;
            if (m_busy) begin
                if (m_cnt == NB - 1) begin
                    m_done = 1;
                    m_acc  = m_prom ? 1'b1 : (m_grp ? tbl_m[hash_idx(m_addr)] : m_hit);
                    m_busy = 0;
                end else begin
                    m_cnt++;
                end
            end else if (rx_addr_valid) begin
                m_busy = 1;
                m_cnt  = 0;
                m_addr = rx_dst_addr;
                m_grp  = rx_dst_addr[40];
                m_prom = promisc_en;
                m_hit  = rx_exact_hit;
            end
            if (tbl_wr) tbl_m[tbl_wdata[IW-1:0]] = tbl_wdata[IW];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            check(filt_done == m_done, "done vs model", {31'd0, filt_done}, {31'd0, m_done});
            check(filt_accept == m_acc, "accept vs model", {31'd0, filt_accept}, {31'd0, m_acc});
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr_entry(input logic [IW-1:0] idx, input logic val, input logic [21:0] junk);
        @(negedge clk);
        tbl_wr    = 1'b1;
        tbl_wdata = {junk, val, idx};
        @(negedge clk);
        tbl_wr    = 1'b0;
    endtask

    task automatic lookup(input logic [47:0] a, input logic hit, input logic prom,
                          input logic exp);
        @(negedge clk);
        rx_dst_addr   = a;
        rx_exact_hit  = hit;
        promisc_en    = prom;
        rx_addr_valid = 1'b1;
        @(negedge clk);
        rx_addr_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(filt_done == 1'b0, "R2 done early", {31'd0, filt_done}, 32'd0);
        @(negedge clk);
        check(filt_done == 1'b1, "R2 done at edge k+6", {31'd0, filt_done}, 32'd1);
        check(filt_accept == exp, "verdict", {31'd0, filt_accept}, {31'd0, exp});
    endtask

    localparam logic [47:0] G1 = 48'h01005E000001;
    localparam logic [47:0] G2 = 48'h333300000001;
    localparam logic [47:0] G3 = 48'h0180C2000000;
    localparam logic [47:0] U1 = 48'h001122334455;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog (all): actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int dones;
        logic [47:0] ra;
        logic        pick;

        repeat (4) @(negedge clk);
        cur_req = "R1";
        check(filt_done == 1'b0, "reset done", {31'd0, filt_done}, 32'd0);
        check(filt_accept == 1'b0, "reset accept", {31'd0, filt_accept}, 32'd0);
        rst = 1'b0;

        // R1 / R7: empty table rejects a group address
        cur_req = "R1";
        lookup(G1, 1'b0, 1'b0, 1'b0);

        // R4 / R7: set one entry, its address passes, another does not
        cur_req = "R7";
        wr_entry(hash_idx(G1), 1'b1, 22'd0);
        lookup(G1, 1'b0, 1'b0, 1'b1);
        cur_req = "R5";
        if (hash_idx(G2) != hash_idx(G1)) lookup(G2, 1'b0, 1'b0, 1'b0);

        // R4: clear with junk high bits, then set again with junk
        cur_req = "R4";
        wr_entry(hash_idx(G1), 1'b0, 22'h3FFFFF);
        lookup(G1, 1'b0, 1'b0, 1'b0);
        wr_entry(hash_idx(G1), 1'b1, 22'h155555);
        lookup(G1, 1'b0, 1'b0, 1'b1);

        // R8: individual address follows the exact-match input only
        cur_req = "R8";
        wr_entry(hash_idx(U1), 1'b1, 22'd0);
        lookup(U1, 1'b0, 1'b0, 1'b0);
        lookup(U1, 1'b1, 1'b0, 1'b1);

        // R6: exact hit has no effect on a group address
        cur_req = "R6";
        wr_entry(hash_idx(G3), 1'b0, 22'd0);
        lookup(G3, 1'b1, 1'b0, 1'b0);

        // R9: promiscuous accepts regardless
        cur_req = "R9";
        lookup(G3, 1'b0, 1'b1, 1'b1);
        lookup(U1, 1'b0, 1'b1, 1'b1);

        // R3: strobe held high; strobes while busy are ignored
        cur_req = "R3";
        dones = 0;
        @(negedge clk);
        rx_dst_addr = G1; rx_exact_hit = 1'b0; promisc_en = 1'b0;
        rx_addr_valid = 1'b1;
        for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (filt_done) dones++;
        end
        rx_addr_valid = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (filt_done) dones++;
        end
        check(dones == 5, "R3 done count", dones, 32'd5);

        // R5 / R7: random group addresses in a partly filled table
        cur_req = "R7";
        for (int n = 0; n < 40; n++) begin
            ra = {$urandom, $urandom};
            ra[40] = 1'b1;
            pick = $urandom_range(0, 1) == 1;
            wr_entry(hash_idx(ra), pick, 22'($urandom));
            lookup(ra, 1'b0, 1'b0, pick);
        end

        // R4: write landing right before the lookup edge (model compares)
        cur_req = "R4";
        @(negedge clk);
        rx_dst_addr = G2; rx_addr_valid = 1'b1;
        @(negedge clk);
        rx_addr_valid = 1'b0;
        repeat (4) @(negedge clk);
        tbl_wr = 1'b1; tbl_wdata = {22'd0, 1'b1, hash_idx(G2)};
        @(negedge clk);
        tbl_wr = 1'b0;
        repeat (4) @(negedge clk);

        // R10: all entries set accepts every group address
        cur_req = "R10";
        for (int e = 0; e < NENT; e++) begin
            @(negedge clk);
            tbl_wr = 1'b1; tbl_wdata = {22'd0, 1'b1, IW'(e)};
        end
        @(negedge clk);
        tbl_wr = 1'b0;
        for (int n = 0; n < 20; n++) begin
            ra = {$urandom, $urandom};
            ra[40] = 1'b1;
            lookup(ra, 1'b0, 1'b0, 1'b1);
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule